// File: doc/BRIEF.md
# Flash Reprogram Mode Control Register

This block is the control and status register that sits between the processor bus and an on-chip flash controller. It decides when the processor may drive the flash with software commands. It also drives the reset line of the flash control circuit and picks which array is visible in boot mode. Entry into reprogram mode is protected: the processor must write the mode bit to 0 and then, as its very next register access, write it to 1. Leaving the mode takes one write of 0.

The block also filters the command port. A command or data write reaches the flash only while the mode is active, only as a 16-bit access at an even address, and only while the flash control circuit is neither held in reset nor recovering. If the reset line is raised while an erase is running, the block locks the flash out for a fixed recovery time. The length of that time is a parameter, counted in clock cycles and derived from the clock frequency. The ready flag in the register stays low for the whole lockout.

The register is 8 bits wide. Bit 0 is the ready flag, bit 1 is the mode bit, bit 3 is the flash-control reset and bit 5 is the user-array select. `reg_rdata` is a combinational view of these bits.

Top module: `flash_mode_ctl`

## Requirements
- R1: After reset, `reg_rdata` reads 8'h01 when `flash_busy` is low. `flash_ctl_rst`, `user_array_sel`, `cpu_rd_block` and `fl_cmd_wr` are all 0, and the set sequence is idle.
- R2: Bit 0 of `reg_rdata` reads 0 whenever `flash_busy` is high or a recovery lockout is running. Otherwise it reads 1.
- R3: The mode bit (bit 1) becomes 1 only on a write with bit 1 = 1 whose previous register access was a write with bit 1 = 0. A register read, or any write with bit 1 = 1, between the two writes cancels the sequence. Idle cycles do not cancel it.
- R4: A single write with bit 1 = 0 clears the mode bit on the next cycle.
- R5: A write with bit 3 = 1 raises `flash_ctl_rst` (and bit 3 of `reg_rdata`) only if the mode bit was already 1 before that write. The reset then holds until a write with bit 3 = 0.
- R6: If `flash_ctl_rst` is raised while `flash_erasing` is high, a lockout of RECOV cycles starts (CLK_KHZ*RECOV_US/1000). During the lockout bit 0 reads 0 and commands are dropped. A reset raised while no erase is running starts no lockout.
- R7: Bit 5 is stored and read back. `user_array_sel` equals bit 5 AND `boot_mode`, so bit 5 has no effect on the array while `boot_mode` is low.
- R8: `fl_cmd_wr` is 1 only when all of these hold: `cmd_wr` is 1, the mode bit is 1, `cmd_wide` is 1, `cmd_addr[0]` is 0, `flash_ctl_rst` is 0 and no lockout is running. When it is 1, `fl_cmd_addr` and `fl_cmd_wdata` equal `cmd_addr` and `cmd_wdata`.
- R9: `cpu_rd_block` is 1 exactly while the mode bit is 1.
- R10: Bits 2, 4, 6 and 7 of `reg_rdata` always read 0, whatever value is written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (counts as an access) |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data |
| cmd_wr | input | 1 | Command/data write strobe |
| cmd_wide | input | 1 | 1 when the access is 16 bits wide |
| cmd_addr | input | AW | Command/data address |
| cmd_wdata | input | DW | Command/data value |
| flash_busy | input | 1 | Flash engine is programming or erasing |
| flash_erasing | input | 1 | Flash engine is erasing |
| boot_mode | input | 1 | Device started in boot mode |
| fl_cmd_wr | output | 1 | Qualified command write to the flash |
| fl_cmd_addr | output | AW | Address forwarded to the flash |
| fl_cmd_wdata | output | DW | Data forwarded to the flash |
| flash_ctl_rst | output | 1 | Reset to the flash control circuit |
| user_array_sel | output | 1 | Selects the user array instead of the boot array |
| cpu_rd_block | output | 1 | Blocks direct processor reads of the array |

## Verification
The bench targets the set sequence at its edges:
- A lone write of 1 after reset.
- A read slipped between the 0 and the 1.
- Back-to-back writes of 0 and then 1.

A design that treats a single write of 1 as enough would enter the mode in the first case, and one that ignores reads would enter it in the second.

It raises the flash-control reset with the mode off, and raises it during an erase. It then counts the exact number of cycles the ready flag stays low. An off-by-one counter, or a lockout that also starts without an erase, shows up as a wrong count.

Odd-address and narrow command writes, and writes made during the lockout, expose a filter that forwards them.

// File: rtl/fmc_pkg.sv
package fmc_pkg;
  localparam int REG_W    = 8;
  localparam int BIT_RDY  = 0;
  localparam int BIT_MODE = 1;
  localparam int BIT_RST  = 3;
  localparam int BIT_USR  = 5;

  // Recovery length in cycles from clock rate in kHz and wait in microseconds.
  function automatic int unsigned recov_cycles(input int unsigned clk_khz,
                                               input int unsigned wait_us);
    recov_cycles = (clk_khz * wait_us) / 1000;
  endfunction

  // A command access is legal when it is 16 bits wide and word aligned.
  function automatic logic cmd_shape_ok(input logic addr0, input logic wide);
    cmd_shape_ok = wide & ~addr0;
  endfunction

  function automatic logic [REG_W-1:0] pack_status(input logic rdy, input logic mode,
                                                   input logic rst, input logic usr);
    logic [REG_W-1:0] v;
    v = '0;
    v[BIT_RDY]  = rdy;
    v[BIT_MODE] = mode;
    v[BIT_RST]  = rst;
    v[BIT_USR]  = usr;
    pack_status = v;
  endfunction
endpackage

// File: rtl/fmc_mode_seq.sv
module fmc_mode_seq (
  input  logic clk,
  input  logic rst_n,
  input  logic wr,
  input  logic rd,
  input  logic wbit,
  output logic mode,
  output logic arm,
  output logic mode_set_evt
);
  assign mode_set_evt = wr & wbit & arm;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode <= 1'b0;
      arm  <= 1'b0;
    end else if (wr) begin
      if (!wbit) begin
        mode <= 1'b0;
        arm  <= 1'b1;
      end else begin
        if (arm) mode <= 1'b1;
        arm <= 1'b0;
      end
    end else if (rd) begin
      arm <= 1'b0;
    end
  end
endmodule

// File: rtl/fmc_recovery.sv
module fmc_recovery #(
  parameter int unsigned CYC = 625000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic lockout
);
  localparam int CW = $clog2(CYC + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (start)      cnt <= CW'(CYC);
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign lockout = (cnt != '0);
endmodule

// File: rtl/fmc_cmd_gate.sv
module fmc_cmd_gate #(
  parameter int AW = 16,
  parameter int DW = 16,
  parameter bit ZERO_IDLE = 1'b1
) (
  input  logic          cmd_wr,
  input  logic          cmd_wide,
  input  logic [AW-1:0] cmd_addr,
  input  logic [DW-1:0] cmd_wdata,
  input  logic          allow,
  output logic          fl_wr,
  output logic [AW-1:0] fl_addr,
  output logic [DW-1:0] fl_wdata
);
  import fmc_pkg::*;
  logic pass;
  assign pass  = cmd_wr & allow & cmd_shape_ok(cmd_addr[0], cmd_wide);
  assign fl_wr = pass;

  generate
    if (ZERO_IDLE) begin : g_zero
      assign fl_addr  = pass ? cmd_addr  : '0;
      assign fl_wdata = pass ? cmd_wdata : '0;
    end else begin : g_thru
      assign fl_addr  = cmd_addr;
      assign fl_wdata = cmd_wdata;
    end
  endgenerate
endmodule

// File: rtl/flash_mode_ctl.sv
module flash_mode_ctl #(
  parameter int          AW       = 16,
  parameter int          DW       = 16,
  parameter int unsigned CLK_KHZ  = 125000,
  parameter int unsigned RECOV_US = 5000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [7:0]    reg_wdata,
  output logic [7:0]    reg_rdata,
  input  logic          cmd_wr,
  input  logic          cmd_wide,
  input  logic [AW-1:0] cmd_addr,
  input  logic [DW-1:0] cmd_wdata,
  input  logic          flash_busy,
  input  logic          flash_erasing,
  input  logic          boot_mode,
  output logic          fl_cmd_wr,
  output logic [AW-1:0] fl_cmd_addr,
  output logic [DW-1:0] fl_cmd_wdata,
  output logic          flash_ctl_rst,
  output logic          user_array_sel,
  output logic          cpu_rd_block
);
  import fmc_pkg::*;
  localparam int unsigned RECOV = (recov_cycles(CLK_KHZ, RECOV_US) == 0) ? 1 :
                                  recov_cycles(CLK_KHZ, RECOV_US);

  logic mode, arm, mode_set_evt;
  logic rst_q, usr_q;
  logic rst_set_evt, rst_clr_evt, lock_start, lockout, cmd_allow;
  logic unused_wbits;

  assign unused_wbits = ^{reg_wdata[7:6], reg_wdata[4], reg_wdata[2], reg_wdata[0]};

  fmc_mode_seq u_seq (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .rd(reg_rd),
    .wbit(reg_wdata[BIT_MODE]), .mode(mode), .arm(arm), .mode_set_evt(mode_set_evt)
  );

  // Reset bit: set only with the mode already on, cleared by any write of 0.
  assign rst_set_evt = reg_wr & reg_wdata[BIT_RST] & mode & ~rst_q;
  assign rst_clr_evt = reg_wr & ~reg_wdata[BIT_RST];
  assign lock_start  = rst_set_evt & flash_erasing;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_q <= 1'b0;
      usr_q <= 1'b0;
    end else if (reg_wr) begin
      usr_q <= reg_wdata[BIT_USR];
      if (rst_set_evt)      rst_q <= 1'b1;
      else if (rst_clr_evt) rst_q <= 1'b0;
    end
  end

  fmc_recovery #(.CYC(RECOV)) u_rec (
    .clk(clk), .rst_n(rst_n), .start(lock_start), .lockout(lockout)
  );

  assign cmd_allow = mode & ~rst_q & ~lockout;

  fmc_cmd_gate #(.AW(AW), .DW(DW), .ZERO_IDLE(1'b1)) u_gate (
    .cmd_wr(cmd_wr), .cmd_wide(cmd_wide), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
    .allow(cmd_allow), .fl_wr(fl_cmd_wr), .fl_addr(fl_cmd_addr), .fl_wdata(fl_cmd_wdata)
  );

  assign reg_rdata      = pack_status(~(flash_busy | lockout), mode, rst_q, usr_q);
  assign flash_ctl_rst  = rst_q;
  assign user_array_sel = usr_q & boot_mode;
  assign cpu_rd_block   = mode;
endmodule

// File: rtl/fmc_checker.sv
module fmc_checker (
  input logic clk,
  input logic rst_n,
  input logic reg_wr,
  input logic reg_rd,
  input logic wbit_mode,
  input logic wbit_rst,
  input logic rdy,
  input logic mode,
  input logic arm,
  input logic mode_set_evt,
  input logic rst_out,
  input logic lockout,
  input logic erasing,
  input logic busy,
  input logic boot,
  input logic user_sel,
  input logic cmd_wide,
  input logic cmd_a0,
  input logic fl_wr
);
  AST_RDY_BUSY: assert property (@(posedge clk) disable iff (!rst_n) busy |-> !rdy); // R2
  AST_MODE_ONLY_ARMED: assert property (@(posedge clk) disable iff (!rst_n) $rose(mode) |-> $past(mode_set_evt)); // R3
  AST_READ_DISARMS: assert property (@(posedge clk) disable iff (!rst_n) (reg_rd && !reg_wr) |=> !arm); // R3
  AST_MODE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n) (reg_wr && !wbit_mode) |=> !mode); // R4
  AST_RST_NEEDS_MODE: assert property (@(posedge clk) disable iff (!rst_n) $rose(rst_out) |-> $past(mode)); // R5
  AST_RST_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) (rst_out && !(reg_wr && !wbit_rst)) |=> rst_out); // R5
  AST_LOCK_CAUSE: assert property (@(posedge clk) disable iff (!rst_n) $rose(lockout) |-> ($past(erasing) && $rose(rst_out))); // R6
  AST_LOCK_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n) lockout |-> !rdy); // R6
  AST_USER_NEEDS_BOOT: assert property (@(posedge clk) disable iff (!rst_n) user_sel |-> boot); // R7
  AST_CMD_FILTER: assert property (@(posedge clk) disable iff (!rst_n) fl_wr |-> (mode && cmd_wide && !cmd_a0 && !rst_out && !lockout)); // R8
endmodule

bind flash_mode_ctl fmc_checker u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
  .wbit_mode(reg_wdata[1]), .wbit_rst(reg_wdata[3]), .rdy(reg_rdata[0]),
  .mode(mode), .arm(arm), .mode_set_evt(mode_set_evt), .rst_out(flash_ctl_rst),
  .lockout(lockout), .erasing(flash_erasing), .busy(flash_busy), .boot(boot_mode),
  .user_sel(user_array_sel), .cmd_wide(cmd_wide), .cmd_a0(cmd_addr[0]), .fl_wr(fl_cmd_wr)
);

// File: tb/sim_flash_mode_ctl.sv
`timescale 1ns/1ps
module sim_flash_mode_ctl;
  localparam int AW = 16;
  localparam int DW = 16;
  localparam int TB_CYC = 125000 * 1 / 1000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr = 0, reg_rd = 0;
  logic [7:0] reg_wdata = '0, reg_rdata;
  logic cmd_wr = 0, cmd_wide = 0;
  logic [AW-1:0] cmd_addr = '0, fl_cmd_addr;
  logic [DW-1:0] cmd_wdata = '0, fl_cmd_wdata;
  logic flash_busy = 0, flash_erasing = 0, boot_mode = 0;
  logic fl_cmd_wr, flash_ctl_rst, user_array_sel, cpu_rd_block;

  int tests = 0, fails = 0;
  bit m_mode, m_arm, m_rst, m_usr;
  int m_lock;

  always #4 clk = ~clk;

  flash_mode_ctl #(.AW(AW), .DW(DW), .CLK_KHZ(125000), .RECOV_US(1)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .cmd_wr(cmd_wr), .cmd_wide(cmd_wide), .cmd_addr(cmd_addr),
    .cmd_wdata(cmd_wdata), .flash_busy(flash_busy), .flash_erasing(flash_erasing),
    .boot_mode(boot_mode), .fl_cmd_wr(fl_cmd_wr), .fl_cmd_addr(fl_cmd_addr),
    .fl_cmd_wdata(fl_cmd_wdata), .flash_ctl_rst(flash_ctl_rst),
    .user_array_sel(user_array_sel), .cpu_rd_block(cpu_rd_block)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk); reg_wr = 1; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd();
    @(negedge clk); reg_rd = 1;
    @(negedge clk); reg_rd = 0;
  endtask

  task automatic probe(input logic [AW-1:0] a, input logic wide, input logic exp, input string tag);
    @(negedge clk); cmd_wr = 1; cmd_wide = wide; cmd_addr = a; cmd_wdata = 16'hC3A5;
    #1;
    chk(tag, fl_cmd_wr, exp);
    if (exp) begin
      chk(tag, fl_cmd_addr, a);
      chk(tag, fl_cmd_wdata, 16'hC3A5);
    end
    cmd_wr = 0;
  endtask

  function automatic logic [7:0] m_rdata(input logic busy);
    logic [7:0] v;
    v = '0;
    v[0] = !(busy || m_lock != 0);
    v[1] = m_mode; v[3] = m_rst; v[5] = m_usr;
    return v;
  endfunction

  function automatic logic m_cmd(input logic w, input logic wide, input logic a0);
    return w && wide && !a0 && m_mode && !m_rst && m_lock == 0;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    fails++; tests++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int n;
    void'($urandom(32'd4177));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 rdata", reg_rdata, 8'h01);
    chk("R1 rst", flash_ctl_rst, 0);
    chk("R1 usr", user_array_sel, 0);
    chk("R1 block", cpu_rd_block, 0);
    chk("R1 cmd", fl_cmd_wr, 0);
    // R3 lone write of 1 after reset does nothing
    wr(8'h02);
    chk("R3 lone one", reg_rdata[1], 0);
    // R10 reserved bits read zero
    wr(8'hD4);
    chk("R10 reserved", reg_rdata & 8'hD4, 8'h00);
    // R3 read between 0 and 1 cancels
    rd();
    wr(8'h02);
    chk("R3 read cancels", reg_rdata[1], 0);
    // R3 0 then 1, with idle cycle between
    wr(8'h00);
    @(negedge clk);
    wr(8'h02);
    chk("R3 sequence sets", reg_rdata[1], 1);
    chk("R9 block on", cpu_rd_block, 1);
    // R8 command filtering
    probe(16'h0010, 1, 1, "R8 even wide");
    probe(16'h0011, 1, 0, "R8 odd dropped");
    probe(16'h0012, 0, 0, "R8 narrow dropped");
    // R4 single clear
    wr(8'h00);
    chk("R4 clear", reg_rdata[1], 0);
    chk("R9 block off", cpu_rd_block, 0);
    probe(16'h0010, 1, 0, "R8 mode off");
    // R5 reset bit ignored with mode off
    wr(8'h08);
    chk("R5 gated", flash_ctl_rst, 0);
    // enter mode; set reset with no erase: no lockout
    wr(8'h00); wr(8'h02);
    wr(8'h0A);
    chk("R5 set", flash_ctl_rst, 1);
    chk("R6 no erase no lock", reg_rdata, 8'h0B);
    probe(16'h0020, 1, 0, "R8 held in reset");
    wr(8'h0A);
    chk("R5 holds", flash_ctl_rst, 1);
    wr(8'h02);
    chk("R5 release", flash_ctl_rst, 0);
    chk("R4 mode kept", reg_rdata[1], 1);
    // R6 reset during erase -> lockout of TB_CYC cycles
    flash_erasing = 1;
    wr(8'h0A);
    flash_erasing = 0;
    n = 0;
    while (reg_rdata[0] == 0 && n < 10 * TB_CYC) begin
      n++;
      cmd_wr = 1; cmd_wide = 1; cmd_addr = 16'h0040;
      #1;
      if (fl_cmd_wr) chk("R6 cmd in lockout", fl_cmd_wr, 0);
      cmd_wr = 0;
      @(negedge clk);
    end
    chk("R6 lockout length", n, TB_CYC);
    wr(8'h02);
    probe(16'h0040, 1, 1, "R8 after recovery");
    // R7 user array select
    boot_mode = 0;
    wr(8'h22);
    chk("R7 stored", reg_rdata[5], 1);
    chk("R7 no boot", user_array_sel, 0);
    @(negedge clk); boot_mode = 1; #1;
    chk("R7 boot", user_array_sel, 1);
    // R2 busy
    flash_busy = 1; #1;
    chk("R2 busy", reg_rdata[0], 0);
    flash_busy = 0; #1;
    chk("R2 idle", reg_rdata[0], 1);

    // Random phase against bench model
    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1;
    m_mode = 0; m_arm = 0; m_rst = 0; m_usr = 0; m_lock = 0;
    for (int i = 0; i < 3000; i++) begin
      int op;
      bit nm, na, nr;
      int nl;
      @(negedge clk);
      op = $urandom % 8;
      reg_wr = (op < 3); reg_rd = (op == 3);
      reg_wdata = $urandom;
      if ($urandom % 3 == 0) reg_wdata[3] = 0;
      flash_busy = ($urandom % 4 == 0);
      flash_erasing = ($urandom % 12 == 0);
      boot_mode = $urandom;
      cmd_wr = $urandom; cmd_wide = ($urandom % 4 != 0);
      cmd_addr = $urandom; cmd_wdata = $urandom;
      #1;
      chk("R2 random rdata", reg_rdata, m_rdata(flash_busy));
      chk("R8 random cmd", fl_cmd_wr, m_cmd(cmd_wr, cmd_wide, cmd_addr[0]));
      chk("R7 random usr", user_array_sel, m_usr & boot_mode);
      nm = m_mode; na = m_arm; nr = m_rst;
      nl = (m_lock > 0) ? m_lock - 1 : 0;
      if (reg_wr) begin
        if (!reg_wdata[1]) begin nm = 0; na = 1; end
        else begin if (m_arm) nm = 1; na = 0; end
        if (reg_wdata[3] && m_mode && !m_rst) begin
          nr = 1;
          if (flash_erasing) nl = TB_CYC;
        end else if (!reg_wdata[3]) nr = 0;
        m_usr = reg_wdata[5];
      end else if (reg_rd) na = 0;
      m_mode = nm; m_arm = na; m_rst = nr; m_lock = nl;
    end
    reg_wr = 0; reg_rd = 0; cmd_wr = 0;
    @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule